// File: doc/BRIEF.md
# Ping-Pong Buffered DMA Channel

This block is one peripheral DMA channel. It has two buffer slots, A and B, and moves data between memory and a simple peripheral. Each slot holds a start address and a byte count. The channel drains the active slot. When that slot's count reaches zero, the slot is marked done. If the other slot has been started, the channel switches to it on its own. A buffer-in-use flag reports which slot is active. Software reads that flag to know which idle slot it can refill while the channel keeps running.

The peripheral asks for service by pulsing a request line. For each request the channel runs one burst of four or eight beats, or fewer if the active buffer runs out first. A beat moves one byte or one 16-bit halfword. For 16-bit data, the byte order between memory and the peripheral can be swapped. A single status word holds the run, interrupt-enable, error, per-slot done and start flags and the buffer-in-use flag. It is reached at three word offsets: write-ones-to-set, write-ones-to-clear and read. An interrupt line reports the done and error conditions.

Top module: `pingPongDma`

## Requirements
- R1: After reset the status word, the configuration word and both slots read 0, and `irq`, `memReq` and `perAck` are low.
- R2: Word 1 sets the status bits written as 1, word 2 clears them, and word 3 reads the live status; writes to word 3 are ignored. Status bits: 0 run, 1 irq enable, 2 error, 3 A done, 4 A started, 5 B done, 6 B started, 7 buffer-in-use (1 = B active), which software cannot write.
- R3: While a slot is active, each beat advances its address register by the beat width and decrements its count register by the same amount. Both values can be read back: word 4/5 for A address/count, word 6/7 for B.
- R4: When the active slot's count reaches zero, its started bit clears and its done bit sets. If the other slot's started bit is set, buffer-in-use toggles and the next burst uses that slot.
- R5: If the other slot is not started when the active one finishes, buffer-in-use is unchanged and no further beats occur.
- R6: `irq` is high exactly when irq enable is set and at least one of error, A done or B done is set; writing those bits to the clear word drops it.
- R7: Configuration word 0: bit 0 selects the direction (1 = peripheral to memory), bit 1 swaps bytes for 16-bit beats, bit 2 selects 8-beat bursts instead of 4, and bit 3 selects 16-bit beats instead of 8-bit ones. 8-bit beats use data bits [7:0] and zero the upper byte.
- R8: One request starts a single burst of 4 or 8 beats, ended early by the end of the active buffer.
- R9: Clearing run lets the burst in flight finish and stops new bursts while keeping the slot contents; setting run again resumes from the same address and count.
- R10: A peripheral fault during a beat sets error and clears run. That beat is not counted and the burst stops.
- R11: Address writes force bits [1:0] to zero; count writes keep only the low 13 bits (maximum 0x1FFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWordSel | input | 3 | Register word index (byte offset / 4) |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for the selected word |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Byte address of the current beat |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory access complete |
| perReq | input | 1 | Peripheral service request |
| perAck | output | 1 | One-cycle peripheral beat strobe |
| perWdata | output | 16 | Data to the peripheral, valid with perAck |
| perRdata | input | 16 | Data from the peripheral, sampled with perAck |
| perFault | input | 1 | Peripheral fault, sampled with perAck |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these rules:
- a finished slot has its done bit set and its started bit cleared;
- buffer-in-use moves only when a buffer finishes;
- a fault leaves error set and run cleared;
- a memory request is held until it is acknowledged;
- the beat index never passes the burst length;
- a clear write of the done and error bits drops the interrupt.

Only the directed scenarios can show the data path and the byte swap, the exact number of beats per request, the address and count positions read back after a pause and resume, and the hand-over from A to B with each slot's own data.

// File: rtl/pingPongDmaPkg.sv
package pingPongDmaPkg;

  typedef struct packed {
    logic commit;
    logic fault;
    logic latchMem;
    logic latchPer;
  } dmaStrobes_t;

  typedef enum logic [1:0] {PH_IDLE, PH_MEM, PH_PER} phase_t;

  typedef enum logic [2:0] {
    SEL_CFG  = 3'd0,
    SEL_SET  = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_READ = 3'd3,
    SEL_AADR = 3'd4,
    SEL_ACNT = 3'd5,
    SEL_BADR = 3'd6,
    SEL_BCNT = 3'd7
  } regSel_t;

  localparam int ST_RUN    = 0;
  localparam int ST_IE     = 1;
  localparam int ST_ERR    = 2;
  localparam int ST_DONEA  = 3;
  localparam int ST_STARTA = 4;
  localparam int ST_DONEB  = 5;
  localparam int ST_STARTB = 6;

  localparam int CF_DIR    = 0;
  localparam int CF_SWAP   = 1;
  localparam int CF_BURST8 = 2;
  localparam int CF_WIDE   = 3;

endpackage

// File: rtl/dmaControl.sv
module dmaControl
  import pingPongDmaPkg::*;
#(
  parameter int BURST_SHORT = 4,
  parameter int BURST_LONG  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        actStart,
  input  logic        dir,
  input  logic        burst8,
  input  logic        lastBeat,
  input  logic        perReq,
  input  logic        perFault,
  input  logic        memAck,
  output logic        memReq,
  output logic        perAck,
  output dmaStrobes_t strobes
);

  localparam int IDX_W = $clog2(BURST_LONG);

  phase_t           phase, phaseNext;
  logic [IDX_W-1:0] beatIdx;
  logic             beatEnd;
  logic             burstLast;
  phase_t           firstPhase;

  assign firstPhase = dir ? PH_PER : PH_MEM;
  assign burstLast  = burst8 ? (beatIdx == IDX_W'(BURST_LONG - 1))
                             : (beatIdx == IDX_W'(BURST_SHORT - 1));

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    memReq    = 1'b0;
    perAck    = 1'b0;
    beatEnd   = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (run && actStart && perReq) phaseNext = firstPhase;
      end
      PH_MEM: begin
        memReq = 1'b1;
        if (memAck) begin
          if (dir) begin
            beatEnd = 1'b1;
          end else begin
            strobes.latchMem = 1'b1;
            phaseNext = PH_PER;
          end
        end
      end
      PH_PER: begin
        perAck = 1'b1;
        if (perFault) begin
          strobes.fault = 1'b1;
          phaseNext = PH_IDLE;
        end else if (dir) begin
          strobes.latchPer = 1'b1;
          phaseNext = PH_MEM;
        end else begin
          beatEnd = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
    if (beatEnd) begin
      strobes.commit = 1'b1;
      phaseNext = (lastBeat || burstLast) ? PH_IDLE : firstPhase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      beatIdx <= '0;
    end else begin
      phase <= phaseNext;
      if (phase == PH_IDLE)                    beatIdx <= '0;
      else if (beatEnd && phaseNext != PH_IDLE) beatIdx <= beatIdx + 1'b1;
    end
  end

  // R8: the beat index stays inside the selected burst length
  p_burst_cap_r8: assert property (@(posedge clk) disable iff (rst)
    int'(beatIdx) < (burst8 ? BURST_LONG : BURST_SHORT));

  // R3: a memory request is held until it is acknowledged
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck |=> memReq);

  // R3: in the memory-to-peripheral direction each peripheral strobe lasts one cycle
  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    perAck && !perFault && !dir |=> !perAck);

endmodule

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import pingPongDmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        regWordSel,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  dmaStrobes_t       strobes,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] perRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] perWdata,
  output logic              run,
  output logic              actStart,
  output logic              dir,
  output logic              burst8,
  output logic              lastBeat,
  output logic              irq
);

  localparam int HALF = DATA_W / 2;

  logic [3:0]        cfgReg;
  logic [6:0]        flags, flagsSw, flagsNext;
  logic              biu, biuNext;
  logic [ADDR_W-1:0] bufAddr [2];
  logic [CNT_W-1:0]  bufCnt [2];
  logic [DATA_W-1:0] dataLatch;
  logic [6:0]        swSet, swClr;
  logic [CNT_W-1:0]  stepCnt;
  logic [ADDR_W-1:0] stepAddr;
  logic              wide, bufFinish;
  regSel_t           sel;

  assign sel      = regSel_t'(regWordSel);
  assign wide     = cfgReg[CF_WIDE];
  assign stepCnt  = wide ? CNT_W'(2) : CNT_W'(1);
  assign stepAddr = wide ? ADDR_W'(2) : ADDR_W'(1);
  assign lastBeat = bufCnt[biu] <= stepCnt;
  assign bufFinish = strobes.commit && lastBeat;

  assign swSet   = (regWr && sel == SEL_SET) ? regWdata[6:0] : 7'd0;
  assign swClr   = (regWr && sel == SEL_CLR) ? regWdata[6:0] : 7'd0;
  assign flagsSw = (flags | swSet) & ~swClr;

  always_comb begin
    flagsNext = flagsSw;
    biuNext   = biu;
    if (bufFinish) begin
      if (!biu) begin
        flagsNext[ST_STARTA] = 1'b0;
        flagsNext[ST_DONEA]  = 1'b1;
        if (flagsSw[ST_STARTB]) biuNext = 1'b1;
      end else begin
        flagsNext[ST_STARTB] = 1'b0;
        flagsNext[ST_DONEB]  = 1'b1;
        if (flagsSw[ST_STARTA]) biuNext = 1'b0;
      end
    end
    if (strobes.fault) begin
      flagsNext[ST_ERR] = 1'b1;
      flagsNext[ST_RUN] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      biu    <= 1'b0;
      cfgReg <= '0;
    end else begin
      flags <= flagsNext;
      biu   <= biuNext;
      if (regWr && sel == SEL_CFG) cfgReg <= regWdata[3:0];
    end
  end

  for (genvar s = 0; s < 2; s++) begin : gSlot
    localparam logic [2:0] ADR_SEL = 3'(4 + 2 * s);
    localparam logic [2:0] CNT_SEL = 3'(5 + 2 * s);
    always_ff @(posedge clk) begin
      if (rst) begin
        bufAddr[s] <= '0;
        bufCnt[s]  <= '0;
      end else if (strobes.commit && biu == 1'(s)) begin
        bufAddr[s] <= bufAddr[s] + stepAddr;
        bufCnt[s]  <= lastBeat ? '0 : bufCnt[s] - stepCnt;
      end else if (regWr && regWordSel == ADR_SEL) begin
        bufAddr[s] <= {regWdata[ADDR_W-1:2], 2'b00};
      end else if (regWr && regWordSel == CNT_SEL) begin
        bufCnt[s] <= regWdata[CNT_W-1:0];
      end
    end
  end

  function automatic logic [DATA_W-1:0] reorder(input logic [DATA_W-1:0] x,
                                                input logic isWide, input logic swap);
    if (!isWide)   return {{HALF{1'b0}}, x[HALF-1:0]};
    else if (swap) return {x[HALF-1:0], x[DATA_W-1:HALF]};
    else           return x;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)                   dataLatch <= '0;
    else if (strobes.latchMem) dataLatch <= reorder(memRdata, wide, cfgReg[CF_SWAP]);
    else if (strobes.latchPer) dataLatch <= reorder(perRdata, wide, cfgReg[CF_SWAP]);
  end

  always_comb begin
    case (sel)
      SEL_CFG:                    regRdata = {28'd0, cfgReg};
      SEL_SET, SEL_CLR, SEL_READ: regRdata = {24'd0, biu, flags};
      SEL_AADR:                   regRdata = 32'(bufAddr[0]);
      SEL_ACNT:                   regRdata = 32'(bufCnt[0]);
      SEL_BADR:                   regRdata = 32'(bufAddr[1]);
      default:                    regRdata = 32'(bufCnt[1]);
    endcase
  end

  assign memAddr  = bufAddr[biu];
  assign memWdata = dataLatch;
  assign perWdata = dataLatch;
  assign run      = flags[ST_RUN];
  assign actStart = biu ? flags[ST_STARTB] : flags[ST_STARTA];
  assign dir      = cfgReg[CF_DIR];
  assign burst8   = cfgReg[CF_BURST8];
  assign irq      = flags[ST_IE] & (flags[ST_ERR] | flags[ST_DONEA] | flags[ST_DONEB]);

  // R4: slot A finishing leaves A done set and A started cleared
  p_done_sets_r4: assert property (@(posedge clk) disable iff (rst)
    bufFinish && !biu && !regWr |=> flags[ST_DONEA] && !flags[ST_STARTA]);

  // R4: the active slot changes only when a buffer finishes
  p_biu_moves_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(biu) |-> $past(bufFinish));

  // R10: a fault leaves error set and run cleared
  p_fault_halts_r10: assert property (@(posedge clk) disable iff (rst)
    strobes.fault && !regWr |=> flags[ST_ERR] && !flags[ST_RUN]);

  // R6: clearing all done and error bits drops the interrupt
  p_irq_ack_r6: assert property (@(posedge clk) disable iff (rst)
    regWr && sel == SEL_CLR && (&{regWdata[ST_ERR], regWdata[ST_DONEA], regWdata[ST_DONEB]})
      && !strobes.commit && !strobes.fault |=> !irq);

endmodule

// File: rtl/pingPongDma.sv
module pingPongDma
  import pingPongDmaPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 13,
  parameter int DATA_W      = 16,
  parameter int BURST_SHORT = 4,
  parameter int BURST_LONG  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        regWordSel,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  input  logic              perReq,
  output logic              perAck,
  output logic [DATA_W-1:0] perWdata,
  input  logic [DATA_W-1:0] perRdata,
  input  logic              perFault,
  output logic              irq
);

  dmaStrobes_t strobes;
  logic run, actStart, dir, burst8, lastBeat;

  dmaControl #(.BURST_SHORT(BURST_SHORT), .BURST_LONG(BURST_LONG)) uCtrl (
    .clk(clk), .rst(rst), .run(run), .actStart(actStart), .dir(dir),
    .burst8(burst8), .lastBeat(lastBeat), .perReq(perReq), .perFault(perFault),
    .memAck(memAck), .memReq(memReq), .perAck(perAck), .strobes(strobes)
  );

  dmaDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rst(rst), .regWordSel(regWordSel), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .strobes(strobes),
    .memRdata(memRdata), .perRdata(perRdata), .memAddr(memAddr),
    .memWdata(memWdata), .perWdata(perWdata), .run(run), .actStart(actStart),
    .dir(dir), .burst8(burst8), .lastBeat(lastBeat), .irq(irq)
  );

  assign memWe = dir;

endmodule

// File: tb/pingPongDma_test.sv
module pingPongDma_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  regWordSel = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWe, perAck, irq;
  logic [31:0] memAddr;
  logic [15:0] memWdata, perWdata;
  logic [15:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        perReq = 1'b0;
  logic [15:0] perRdata = 16'hBEEF;
  logic        perFault = 1'b0;

  int checks = 0;
  int fails = 0;
  int ackCnt = 0;
  int wrCnt = 0;
  logic [15:0] ackData [64];
  logic [31:0] wrAddr [64];
  logic [15:0] wrData [64];
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingPongDma uut (
    .clk(clk), .rst(rst), .regWordSel(regWordSel), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .perReq(perReq), .perAck(perAck), .perWdata(perWdata), .perRdata(perRdata),
    .perFault(perFault), .irq(irq)
  );

  function automatic logic [15:0] memPat(input logic [31:0] a);
    return a[15:0] * 16'd3 + 16'h0101;
  endfunction

  always @(posedge clk) begin
    memAck   <= memReq && !memAck;
    memRdata <= memPat(memAddr);
    if (perAck) begin
      ackData[ackCnt % 64] <= perWdata;
      ackCnt <= ackCnt + 1;
    end
    if (memReq && memWe && memAck) begin
      wrAddr[wrCnt % 64] <= memAddr;
      wrData[wrCnt % 64] <= memWdata;
      wrCnt <= wrCnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    regWordSel = w; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk);
    regWordSel = w;
    #1 d = regRdata;
  endtask

  task automatic pulseReq();
    @(negedge clk); perReq = 1'b1;
    @(negedge clk); perReq = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(3, v); check("R1 status", v, 0);
    regRead(0, v); check("R1 cfg", v, 0);
    regRead(5, v); check("R1 A count", v, 0);
    check("R1 irq/memReq/perAck", {irq, memReq, perAck}, 0);
  endtask

  task automatic testAliases();
    logic [31:0] v;
    regWrite(1, 32'h02);
    regRead(3, v); check("R2 set ie", v, 32'h02);
    check("R6 irq idle", irq, 0);
    regWrite(1, 32'h08);
    check("R6 irq on done", irq, 1);
    regWrite(2, 32'h08);
    check("R6 irq after clear", irq, 0);
    regWrite(1, 32'hFF);
    regRead(3, v); check("R2 biu read-only", v, 32'h7F);
    regWrite(2, 32'hFF);
    regWrite(3, 32'h7F);
    regRead(3, v); check("R2 read word ignores writes", v, 0);
  endtask

  task automatic testAlign();
    logic [31:0] v;
    regWrite(4, 32'h0000_1003);
    regRead(4, v); check("R11 addr align", v, 32'h1000);
    regWrite(5, 32'h0000_FFFF);
    regRead(5, v); check("R11 count mask", v, 32'h1FFF);
  endtask

  task automatic testSingleSlot();
    logic [31:0] v;
    int base;
    regWrite(0, 0);
    regWrite(4, 32'h100);
    regWrite(5, 6);
    regWrite(1, 32'h13);
    base = ackCnt;
    pulseReq(); idle(60);
    check("R8 four beats", ackCnt - base, 4);
    for (int i = 0; i < 4; i++)
      check("R3 data to peripheral", ackData[(base + i) % 64], {8'h0, memPat(32'h100 + i)} & 16'h00FF);
    regRead(4, v); check("R3 addr advance", v, 32'h104);
    regRead(5, v); check("R3 count decrement", v, 2);
    base = ackCnt;
    pulseReq(); idle(40);
    check("R8 short tail", ackCnt - base, 2);
    check("R3 tail data", ackData[(base + 1) % 64], memPat(32'h105) & 16'h00FF);
    regRead(3, v); check("R5 A done, no flip", v, 32'h0B);
    check("R6 irq on A done", irq, 1);
    base = ackCnt;
    pulseReq(); idle(30);
    check("R5 no beats after finish", ackCnt - base, 0);
    regWrite(2, 32'hFF);
  endtask

  task automatic testFlip();
    logic [31:0] v;
    int base;
    regWrite(0, 32'h4);
    regWrite(4, 32'h200); regWrite(5, 3);
    regWrite(6, 32'h300); regWrite(7, 2);
    regWrite(1, 32'h51);
    base = ackCnt;
    pulseReq(); idle(60);
    check("R4 burst ends at buffer end", ackCnt - base, 3);
    regRead(3, v); check("R4 flip to B", v, 32'hC9);
    base = ackCnt;
    pulseReq(); idle(60);
    check("R4 B beats", ackCnt - base, 2);
    check("R4 B data0", ackData[base % 64], memPat(32'h300) & 16'h00FF);
    check("R4 B data1", ackData[(base + 1) % 64], memPat(32'h301) & 16'h00FF);
    regRead(3, v); check("R4 B done, stays B", v, 32'hA9);
    regRead(6, v); check("R4 B addr", v, 32'h302);
    regWrite(2, 32'hFF);
    regRead(3, v); check("R4 biu kept", v, 32'h80);
  endtask

  task automatic testInbound();
    logic [31:0] v;
    int base;
    regWrite(0, 32'hB);
    regWrite(6, 32'h400); regWrite(7, 4);
    regWrite(1, 32'h41);
    base = wrCnt;
    pulseReq(); idle(60);
    check("R7 two halfword writes", wrCnt - base, 2);
    check("R7 addr0", wrAddr[base % 64], 32'h400);
    check("R7 addr1", wrAddr[(base + 1) % 64], 32'h402);
    check("R7 swapped data", wrData[base % 64], 16'hEFBE);
    regRead(7, v); check("R7 count zero", v, 0);
    regRead(3, v); check("R7 status", v, 32'hA1);
    regWrite(2, 32'hFF);
  endtask

  task automatic testPauseFault();
    logic [31:0] v;
    int base;
    regWrite(0, 0);
    regWrite(6, 32'h500); regWrite(7, 16);
    regWrite(1, 32'h43);
    base = ackCnt;
    pulseReq(); idle(3);
    regWrite(2, 32'h01);
    idle(60);
    check("R9 burst completes after run cleared", ackCnt - base, 4);
    regRead(7, v); check("R9 count kept", v, 12);
    base = ackCnt;
    pulseReq(); idle(40);
    check("R9 paused", ackCnt - base, 0);
    regWrite(1, 32'h01);
    pulseReq(); idle(60);
    check("R9 resumed", ackCnt - base, 4);
    regRead(7, v); check("R9 count after resume", v, 8);
    regRead(6, v); check("R9 addr after resume", v, 32'h508);
    base = ackCnt;
    perFault = 1'b1;
    pulseReq(); idle(40);
    perFault = 1'b0;
    check("R10 one faulted beat", ackCnt - base, 1);
    regRead(3, v); check("R10 error set, run cleared", v, 32'hC6);
    regRead(7, v); check("R10 beat not counted", v, 8);
    check("R6 irq on error", irq, 1);
    base = ackCnt;
    pulseReq(); idle(30);
    check("R10 halted", ackCnt - base, 0);
    regWrite(2, 32'h04);
    check("R6 irq cleared", irq, 0);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    testReset();
    testAliases();
    testAlign();
    testSingleSlot();
    testFlip();
    testInbound();
    testPauseFault();
    finishRun();
  end

endmodule